// File: doc/BRIEF.md
# Bus Error Transaction Capture Unit

This unit sits beside a bus arbiter and monitor. It keeps a record of the bus transaction that caused the first error event. Several error sources each drive one strobe bit. One set of transaction signals goes with those strobes: the address, the requesting master's ID, the burst flag, the size code and the type code. Each strobe sets a per-source event status bit. Software clears those bits by writing ones to them. While any status bit is set, the captured record is frozen, so it always describes the earliest failure.

The record uses its own reset. Only power-on reset clears it. Hard and soft resets clear the event status bits and leave the record alone, so software can still read the cause of a bus failure after the system has been reset. The captured attribute word is also decoded into three things: a byte count, a master class and a transfer kind. The byte count depends on the burst flag.

Top module: `buserr_capture`

## Requirements
- R1: When any `err_evt` bit is high at a clock edge and `evt_status` is all zero, the edge loads `cap_addr` from `tx_addr` and loads `cap_attr` from the transaction attributes. The new values are visible after that edge.
- R2: While `evt_status` is non-zero, further error strobes leave `cap_addr` and `cap_attr` unchanged.
- R3: If `evt_status` is all zero and several strobes are high in one cycle, only the lowest-numbered of them is set. If `evt_status` is already non-zero, every high strobe sets its own bit.
- R4: A cycle with `clr_wr` high clears each status bit that has a one in `clr_mask`. A strobe in the same cycle sets its bit anyway, because setting wins. Once all bits are clear, the unit captures again as in R1.
- R5: `por_n` low clears the status, `cap_addr` and `cap_attr`. `hrst_n` low or `srst_n` low clears only the status. While either of those two resets is low, strobes neither capture nor set status.
- R6: The `cap_attr` layout uses LSB-0 numbering. Bits 20:16 hold the master ID, bit 11 holds the burst flag (1 = single-beat), bits 10:8 hold the size code and bits 4:0 hold the type code. Every other bit reads 0.
- R7: For a single-beat record (burst flag 1), `byte_cnt` equals the size code for codes 1–7 and equals 8 for code 0. `size_rsvd` is 0.
- R8: For a burst record (burst flag 0), size codes 0, 1 and 2 give 16, 24 and 32 bytes. Codes 3–7 give `byte_cnt` 0 with `size_rsvd` 1.
- R9: `mst_class` decodes the captured master ID as follows: 0→1 (core data), 2→2 (core fetch), 4 or 5→3 (Ethernet), 7→4 (USB), 9→5 (boot I2C), 10→6 (JTAG), 12→7 (SD host), 29→8 (PCI Express), 31→9 (DMA). Every other ID gives 0 (reserved).
- R10: `xfer_kind` decodes the captured type code as follows: 18→1 (single write), 6→2 (burst write), 14 or 30→3 (burst read), 20→4 (illegal single write), 28→5 (illegal single read). Every other code gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| srst_n | input | 1 | Soft reset, active low, asynchronous |
| err_evt | input | NSRC | Per-source error strobes |
| tx_addr | input | AW | Address of the failing transaction |
| tx_mid | input | 5 | Master ID |
| tx_tbst | input | 1 | Burst flag, 1 = single-beat |
| tx_tsize | input | 3 | Size code |
| tx_ttype | input | 5 | Type code |
| clr_wr | input | 1 | Write-one-to-clear strobe for the status |
| clr_mask | input | NSRC | Status bits to clear |
| evt_status | output | NSRC | Event status bits |
| cap_addr | output | AW | Captured address |
| cap_attr | output | 32 | Captured attribute word |
| byte_cnt | output | 6 | Decoded byte count |
| size_rsvd | output | 1 | Reserved burst size code |
| mst_class | output | 4 | Decoded master class |
| xfer_kind | output | 3 | Decoded transfer kind |

## Verification
A new error strobe and a write-one-to-clear of the status can land on the same edge. The bench provokes this by holding a non-zero status, then raising one strobe while clearing every bit in the same cycle. The bench expects the strobe's bit to survive and the other bits to go to zero. It also expects the frozen record to stay as it was, because capture looks at the status value from before that edge. A second collision case raises several strobes at once from an empty status, and only the lowest-numbered bit should be recorded.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

  localparam int ATTR_W    = 32;
  localparam int MID_W     = 5;
  localparam int TSIZE_W   = 3;
  localparam int TTYPE_W   = 5;
  localparam int CNT_W     = 6;
  localparam int MID_LSB   = 16;
  localparam int TBST_BIT  = 11;
  localparam int TSIZE_LSB = 8;
  localparam int TTYPE_LSB = 0;

  typedef enum logic [3:0] {
    MC_RSVD, MC_CORE_DATA, MC_CORE_FETCH, MC_ENET, MC_USB,
    MC_BOOT_I2C, MC_JTAG, MC_SDHOST, MC_PCIE, MC_DMA
  } mst_class_e;

  typedef enum logic [2:0] {
    TK_OTHER, TK_SGL_WR, TK_BST_WR, TK_BST_RD, TK_BAD_SGL_WR, TK_BAD_SGL_RD
  } xfer_kind_e;

endpackage

// File: rtl/buserr_status.sv
module buserr_status #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [NSRC-1:0] err_evt,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] status,
  output logic            idle
);

  logic [NSRC-1:0] err_q;
  logic [NSRC-1:0] first_sel;
  logic [NSRC-1:0] status_d;
  logic [NSRC-1:0] keep;

  assign err_q = arm ? err_evt : '0;
  assign idle  = (status == '0);

  always_comb begin
    first_sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (err_q[i]) first_sel = '0;
      if (err_q[i]) first_sel[i] = 1'b1;
    end
  end

  assign keep = clr_wr ? ~clr_mask : '1;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bit
      always_comb begin
        if (idle) status_d[g] = first_sel[g];
        else      status_d[g] = (status[g] & keep[g]) | err_q[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  // R3: capture from an empty status records at most one source
  a_r3_first_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> $onehot0(status));

  // R4: a strobe on a busy status always leaves its bit set, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((status != '0) && arm) |=> ((status & $past(err_evt)) == $past(err_evt)));

endmodule

// File: rtl/buserr_capreg.sv
module buserr_capreg #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cap_en,
  input  logic          frozen,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] attr_in,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_attr
);

  logic [AW-1:0] addr_d;
  logic [DW-1:0] attr_d;

  always_comb begin
    addr_d = cap_addr;
    attr_d = cap_attr;
    if (cap_en) begin
      addr_d = addr_in;
      attr_d = attr_in;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cap_addr <= '0;
      cap_attr <= '0;
    end else begin
      cap_addr <= addr_d;
      cap_attr <= attr_d;
    end
  end

  // R2: a pending status freezes the record
  a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!por_n)
    frozen |=> ($stable(cap_addr) && $stable(cap_attr)));

endmodule

// File: rtl/buserr_decode.sv
module buserr_decode
  import buserr_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              size_rsvd,
  output logic [3:0]        mst_class,
  output logic [2:0]        xfer_kind
);

  logic [MID_W-1:0]   mid;
  logic               tbst;
  logic [TSIZE_W-1:0] tsize;
  logic [TTYPE_W-1:0] ttype;
  mst_class_e         cls;
  xfer_kind_e         kind;

  assign mid   = attr[MID_LSB +: MID_W];
  assign tbst  = attr[TBST_BIT];
  assign tsize = attr[TSIZE_LSB +: TSIZE_W];
  assign ttype = attr[TTYPE_LSB +: TTYPE_W];

  always_comb begin
    size_rsvd = 1'b0;
    if (tbst) begin
      byte_cnt = (tsize == '0) ? CNT_W'(8) : CNT_W'(tsize);
    end else begin
      unique case (tsize)
        3'd0:    byte_cnt = CNT_W'(16);
        3'd1:    byte_cnt = CNT_W'(24);
        3'd2:    byte_cnt = CNT_W'(32);
        default: begin
          byte_cnt  = '0;
          size_rsvd = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    unique case (mid)
      5'd0:       cls = MC_CORE_DATA;
      5'd2:       cls = MC_CORE_FETCH;
      5'd4, 5'd5: cls = MC_ENET;
      5'd7:       cls = MC_USB;
      5'd9:       cls = MC_BOOT_I2C;
      5'd10:      cls = MC_JTAG;
      5'd12:      cls = MC_SDHOST;
      5'd29:      cls = MC_PCIE;
      5'd31:      cls = MC_DMA;
      default:    cls = MC_RSVD;
    endcase
  end

  always_comb begin
    unique case (ttype)
      5'd18:        kind = TK_SGL_WR;
      5'd6:         kind = TK_BST_WR;
      5'd14, 5'd30: kind = TK_BST_RD;
      5'd20:        kind = TK_BAD_SGL_WR;
      5'd28:        kind = TK_BAD_SGL_RD;
      default:      kind = TK_OTHER;
    endcase
  end

  assign mst_class = cls;
  assign xfer_kind = kind;

endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
  import buserr_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hrst_n,
  input  logic              srst_n,
  input  logic [NSRC-1:0]   err_evt,
  input  logic [AW-1:0]     tx_addr,
  input  logic [MID_W-1:0]  tx_mid,
  input  logic              tx_tbst,
  input  logic [TSIZE_W-1:0] tx_tsize,
  input  logic [TTYPE_W-1:0] tx_ttype,
  input  logic              clr_wr,
  input  logic [NSRC-1:0]   clr_mask,
  output logic [NSRC-1:0]   evt_status,
  output logic [AW-1:0]     cap_addr,
  output logic [ATTR_W-1:0] cap_attr,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              size_rsvd,
  output logic [3:0]        mst_class,
  output logic [2:0]        xfer_kind
);

  logic              stat_rst_n;
  logic              armed;
  logic              idle;
  logic              cap_en;
  logic [ATTR_W-1:0] attr_in;

  assign stat_rst_n = por_n & hrst_n & srst_n;
  assign armed      = hrst_n & srst_n;

  always_comb begin
    attr_in = '0;
    attr_in[MID_LSB +: MID_W]     = tx_mid;
    attr_in[TBST_BIT]             = tx_tbst;
    attr_in[TSIZE_LSB +: TSIZE_W] = tx_tsize;
    attr_in[TTYPE_LSB +: TTYPE_W] = tx_ttype;
  end

  assign cap_en = armed & idle & (|err_evt);

  buserr_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (stat_rst_n),
    .arm      (armed),
    .err_evt  (err_evt),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .status   (evt_status),
    .idle     (idle)
  );

  buserr_capreg #(.AW(AW), .DW(ATTR_W)) u_capreg (
    .clk      (clk),
    .por_n    (por_n),
    .cap_en   (cap_en),
    .frozen   (~idle),
    .addr_in  (tx_addr),
    .attr_in  (attr_in),
    .cap_addr (cap_addr),
    .cap_attr (cap_attr)
  );

  buserr_decode u_decode (
    .attr      (cap_attr),
    .byte_cnt  (byte_cnt),
    .size_rsvd (size_rsvd),
    .mst_class (mst_class),
    .xfer_kind (xfer_kind)
  );

  // R1: first error loads the record
  a_r1_capture: assert property (@(posedge clk) disable iff (!por_n)
    (armed && (evt_status == '0) && (err_evt != '0))
      |=> (cap_addr == $past(tx_addr)) && (cap_attr[MID_LSB +: MID_W] == $past(tx_mid)));

  // R5: hard or soft reset never disturbs the record
  a_r5_keep_on_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!hrst_n || !srst_n) |=> ($stable(cap_addr) && $stable(cap_attr)));

  // R7: single-beat sizes are 1..8 bytes and never reserved
  a_r7_single_range: assert property (@(posedge clk) disable iff (!por_n)
    cap_attr[TBST_BIT] |-> (!size_rsvd && byte_cnt >= 1 && byte_cnt <= 8));

  // R8: a reserved burst size reports no bytes
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
    size_rsvd |-> (byte_cnt == '0 && !cap_attr[TBST_BIT]));

endmodule

// File: tb/buserr_capture_test.sv
`timescale 1ns/1ps
module buserr_capture_test;

  localparam int NSRC = 4;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            por_n = 1'b1, hrst_n = 1'b1, srst_n = 1'b1;
  logic [NSRC-1:0] err_evt = '0;
  logic [AW-1:0]   tx_addr = '0;
  logic [4:0]      tx_mid = '0;
  logic            tx_tbst = 1'b0;
  logic [2:0]      tx_tsize = '0;
  logic [4:0]      tx_ttype = '0;
  logic            clr_wr = 1'b0;
  logic [NSRC-1:0] clr_mask = '0;
  logic [NSRC-1:0] evt_status;
  logic [AW-1:0]   cap_addr;
  logic [31:0]     cap_attr;
  logic [5:0]      byte_cnt;
  logic            size_rsvd;
  logic [3:0]      mst_class;
  logic [2:0]      xfer_kind;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  buserr_capture #(.NSRC(NSRC), .AW(AW)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_attr(input logic [4:0] m, input logic b,
                                           input logic [2:0] s, input logic [4:0] t);
    return (32'(m) << 16) | (32'(b) << 11) | (32'(s) << 8) | 32'(t);
  endfunction

  function automatic logic [5:0] exp_bytes(input logic b, input logic [2:0] s);
    if (b) return (s == 0) ? 6'd8 : 6'(s);
    if (s < 3) return 6'(16 + 8 * s);
    return 6'd0;
  endfunction

  function automatic logic [3:0] exp_class(input logic [4:0] m);
    case (m)
      0: return 1;  2: return 2;  4, 5: return 3;  7: return 4;  9: return 5;
      10: return 6; 12: return 7; 29: return 8;    31: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] exp_kind(input logic [4:0] t);
    case (t)
      18: return 1; 6: return 2; 14, 30: return 3; 20: return 4; 28: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic pulse_err(input logic [NSRC-1:0] m);
    @(negedge clk) err_evt = m;
    @(negedge clk) err_evt = '0;
  endtask

  task automatic w1c(input logic [NSRC-1:0] m, input logic [NSRC-1:0] e);
    @(negedge clk) begin clr_wr = 1'b1; clr_mask = m; err_evt = e; end
    @(negedge clk) begin clr_wr = 1'b0; clr_mask = '0; err_evt = '0; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_addr, keep_attr;
    #1 por_n = 1'b0;
    #10;
    // R5: power-on state
    check("R5 por status", 32'(evt_status), 0);
    check("R5 por addr", cap_addr, 0);
    check("R5 por attr", cap_attr, 0);
    check("R8 por bytes (burst code 0)", 32'(byte_cnt), 16);
    check("R9 por class", 32'(mst_class), 1);
    @(negedge clk) por_n = 1'b1;

    for (int k = 0; k < 64; k++) begin
      logic [4:0] m, t; logic b; logic [2:0] s; logic [31:0] a;
      m = 5'(k); t = 5'((k * 7) % 32); s = 3'(k); b = k[3];
      a = 32'(k) * 32'h0101_0101 ^ 32'hA5C3_0F00;
      tx_addr = a; tx_mid = m; tx_tbst = b; tx_tsize = s; tx_ttype = t;
      pulse_err(4'b0001);
      check("R1 addr", cap_addr, a);
      check("R6 attr layout", cap_attr, exp_attr(m, b, s, t));
      check("R3 status single", 32'(evt_status), 1);
      if (b) check("R7 single size", 32'(byte_cnt), 32'(exp_bytes(b, s)));
      else   check("R8 burst size", 32'(byte_cnt), 32'(exp_bytes(b, s)));
      check("R8 reserved flag", 32'(size_rsvd), 32'(!b && s > 2));
      check("R9 master class", 32'(mst_class), 32'(exp_class(m)));
      check("R10 transfer kind", 32'(xfer_kind), 32'(exp_kind(t)));
      tx_addr = ~a; tx_mid = ~m; tx_ttype = ~t;
      pulse_err(4'b0010);
      check("R2 addr frozen", cap_addr, a);
      check("R2 attr frozen", cap_attr, exp_attr(m, b, s, t));
      check("R3 status accumulates", 32'(evt_status), 3);
      w1c(4'b1111, 4'b0000);
      check("R4 all cleared", 32'(evt_status), 0);
    end

    // R3: simultaneous strobes from empty status
    tx_addr = 32'h1234_5678; tx_mid = 5'd29; tx_tbst = 1; tx_tsize = 3'd4; tx_ttype = 5'd20;
    pulse_err(4'b1100);
    check("R3 lowest wins", 32'(evt_status), 4'b0100);
    check("R1 recapture after clear", cap_addr, 32'h1234_5678);
    pulse_err(4'b0011);
    check("R3 busy sets all", 32'(evt_status), 4'b0111);
    // R4: set and clear in the same cycle
    tx_addr = 32'hDEAD_0000;
    w1c(4'b1111, 4'b0001);
    check("R4 set wins over clear", 32'(evt_status), 4'b0001);
    check("R4 record kept on collision", cap_addr, 32'h1234_5678);
    w1c(4'b0001, 4'b0000);
    check("R4 partial clear", 32'(evt_status), 0);
    pulse_err(4'b1000);
    check("R4 rearmed capture", cap_addr, 32'hDEAD_0000);
    keep_addr = cap_addr; keep_attr = cap_attr;

    // R5: soft reset, with a strobe during it
    @(negedge clk) begin srst_n = 1'b0; err_evt = 4'b0001; tx_addr = 32'h0BAD_0BAD; end
    @(negedge clk) begin
      check("R5 soft clears status", 32'(evt_status), 0);
      check("R5 soft keeps addr", cap_addr, keep_addr);
      check("R5 soft keeps attr", cap_attr, keep_attr);
      err_evt = '0; srst_n = 1'b1;
    end
    @(negedge clk) hrst_n = 1'b0;
    @(negedge clk) begin
      check("R5 hard clears status", 32'(evt_status), 0);
      check("R5 hard keeps addr", cap_addr, keep_addr);
      hrst_n = 1'b1;
    end
    @(negedge clk) por_n = 1'b0;
    @(negedge clk) begin
      check("R5 por clears addr", cap_addr, 0);
      check("R5 por clears attr", cap_attr, 0);
      por_n = 1'b1;
    end
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule